// File: doc/BRIEF.md
# Tiled Crosspoint Route Controller

This controller drives four 8×8 crosspoint tiles arranged as a 2×2 grid to form one 16×16 switch. Each tile row receives one half of the inputs, and these inputs are shared by both tiles in that row. The two tiles in a column have their outputs wired together, so together they drive one bank of eight output nodes. A route request names an output (0–15), an input (0–15) and an enable bit, and is presented on a valid/ready handshake.

For each accepted request, the controller issues tile write commands, one per cycle. Each command carries a tile select, a 3-bit output address and a 4-bit data word. A single update strobe then commits the new writes in all tiles at once. Every enable first clears the same address on the partner tile in the column, so a wired node never has two active drivers.

Out of reset, the tiles' holding registers contain garbage. The controller therefore sweeps every address of every tile with a disable word and commits that sweep before it accepts its first request.

The controller is built from three parts. A sequencing state machine has the states INIT_WR, INIT_COMMIT, IDLE, ROUTE_WR and ROUTE_COMMIT. A request holding register stores the accepted request. A command generator turns the state and counter into tile commands. The transitions are:
- INIT_WR→INIT_COMMIT after the last sweep write.
- INIT_COMMIT→IDLE after the strobe.
- IDLE→ROUTE_WR on handshake acceptance.
- ROUTE_WR→ROUTE_COMMIT after the write to the requested tile row.
- ROUTE_COMMIT→IDLE after the strobe.

Top module: `xbar_route_ctrl`

## Requirements
- R1: After reset, `req_ready` stays low while exactly 32 write commands are issued, one per cycle. These writes cover every (tile, address) pair once, all with data 0. A single `tile_update` pulse follows them, and `req_ready` rises in the cycle after that pulse.
- R2: Tile selection uses `tile_sel[1]` as the tile row, equal to input bit 3, and `tile_sel[0]` as the tile column, equal to output bit 3. `tile_addr` equals output bits 2:0.
- R3: For an enable request, the write to tile (input[3], output[3]) carries data with bit 3 = 1 (output on) and bits 2:0 = input[2:0].
- R4: For an enable request, the write that comes immediately before the enabling write goes to the partner tile: the other row, the same column and the same address, with data 0.
- R5: For a disable request, both tiles of the column receive data 0 at that address. The other-row tile is written first.
- R6: Each request produces exactly two write commands followed by exactly one single-cycle `tile_update` pulse. No write is issued in the same cycle as `tile_update`.
- R7: A request is taken only in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is then low for exactly three cycles. A request held valid while `req_ready` is low produces no commands.
- R8: After every commit, each wired node (column, address) has at most one enabled tile output.
- R9: After each request commits, the enabled state and selected input of every one of the 16 outputs match the requests applied so far. Outputs not named in the request keep their previous route.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Route request present |
| req_ready | output | 1 | Controller can take a request |
| req_out | input | 4 | Output node to route |
| req_in | input | 4 | Input to connect |
| req_en | input | 1 | 1 = connect, 0 = disconnect |
| tile_we | output | 1 | Tile write command strobe |
| tile_sel | output | 2 | Tile select {row, column} |
| tile_addr | output | 3 | Output address within the tile |
| tile_data | output | 4 | {enable, input select[2:0]} |
| tile_update | output | 1 | Commit strobe common to all tiles |

## Verification
Two events can coincide with a pending request. One is the start-up sweep: a request is already held valid while reset releases. The other is the commit strobe of the previous request: the next request is driven in the very cycle `req_ready` returns. The bench provokes the first by asserting `req_valid` with an enabling route before reset ends. It judges the result by requiring that all 32 sweep writes carry zero data and that the held request is served only after the sweep's strobe. It provokes the second with back-to-back requests, and expects exactly two writes and one strobe per request. The tile holding and committed registers are modelled in the bench, so any overlap would appear as a wrong route or a doubly driven node.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

    typedef enum logic [2:0] {
        ST_INIT_WR,
        ST_INIT_COMMIT,
        ST_IDLE,
        ST_ROUTE_WR,
        ST_ROUTE_COMMIT
    } ctl_state_e;

endpackage

// File: rtl/xbar_req_hold.sv
module xbar_req_hold #(
    parameter int PORT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [PORT_W-1:0] in_out,
    input  logic [PORT_W-1:0] in_src,
    input  logic              in_en,
    output logic [PORT_W-1:0] hold_out,
    output logic [PORT_W-1:0] hold_src,
    output logic              hold_en
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_out <= '0;
            hold_src <= '0;
            hold_en  <= 1'b0;
        end else if (fire) begin
            hold_out <= in_out;
            hold_src <= in_src;
            hold_en  <= in_en;
        end
    end

endmodule

// File: rtl/xbar_ctl_fsm.sv
module xbar_ctl_fsm
    import xbar_pkg::*;
#(
    parameter int GRID     = 2,
    parameter int TILE_DIM = 8,
    parameter int CNT_W    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    output ctl_state_e       state_q,
    output logic [CNT_W-1:0] cnt_q
);

    localparam int SWEEP_LEN = GRID * GRID * TILE_DIM;
    localparam logic [CNT_W-1:0] SWEEP_LAST = CNT_W'(SWEEP_LEN - 1);
    localparam logic [CNT_W-1:0] ROUTE_LAST = CNT_W'(GRID - 1);

    ctl_state_e       state_d;
    logic [CNT_W-1:0] cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_INIT_WR;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_INIT_WR: begin
                if (cnt_q == SWEEP_LAST) begin
                    state_d = ST_INIT_COMMIT;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_INIT_COMMIT: state_d = ST_IDLE;
            ST_IDLE: begin
                if (fire) begin
                    state_d = ST_ROUTE_WR;
                    cnt_d   = '0;
                end
            end
            ST_ROUTE_WR: begin
                if (cnt_q == ROUTE_LAST) begin
                    state_d = ST_ROUTE_COMMIT;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_ROUTE_COMMIT: state_d = ST_IDLE;
            default: begin
                state_d = ST_INIT_WR;
                cnt_d   = '0;
            end
        endcase
    end

endmodule

// File: rtl/xbar_cmd_gen.sv
module xbar_cmd_gen
    import xbar_pkg::*;
#(
    parameter int GRID     = 2,
    parameter int TILE_DIM = 8,
    parameter int CNT_W    = 5
) (
    input  ctl_state_e                                  state_q,
    input  logic [CNT_W-1:0]                            cnt_q,
    input  logic [$clog2(TILE_DIM)+$clog2(GRID)-1:0]   rq_out,
    input  logic [$clog2(TILE_DIM)+$clog2(GRID)-1:0]   rq_src,
    input  logic                                        rq_en,
    output logic                                        ready,
    output logic                                        we,
    output logic [2*$clog2(GRID)-1:0]                   sel,
    output logic [$clog2(TILE_DIM)-1:0]                 addr,
    output logic [$clog2(TILE_DIM):0]                   data,
    output logic                                        update
);

    localparam int ADDR_W = $clog2(TILE_DIM);
    localparam int ROW_W  = $clog2(GRID);
    localparam int PORT_W = ADDR_W + ROW_W;

    logic [ROW_W-1:0] row_w;
    logic [ROW_W-1:0] col_w;
    logic [ROW_W-1:0] src_row;

    assign src_row = rq_src[PORT_W-1 -: ROW_W];
    assign sel     = {row_w, col_w};

    always_comb begin
        ready  = 1'b0;
        we     = 1'b0;
        update = 1'b0;
        row_w  = '0;
        col_w  = '0;
        addr   = '0;
        data   = '0;
        unique case (state_q)
            ST_INIT_WR: begin
                we    = 1'b1;
                addr  = cnt_q[ADDR_W-1:0];
                col_w = cnt_q[ADDR_W +: ROW_W];
                row_w = cnt_q[ADDR_W+ROW_W +: ROW_W];
            end
            ST_INIT_COMMIT: update = 1'b1;
            ST_IDLE:        ready  = 1'b1;
            ST_ROUTE_WR: begin
                we    = 1'b1;
                // other rows first, the requested row last
                row_w = src_row + ROW_W'(1) + cnt_q[ROW_W-1:0];
                col_w = rq_out[PORT_W-1 -: ROW_W];
                addr  = rq_out[ADDR_W-1:0];
                if (rq_en && (row_w == src_row))
                    data = {1'b1, rq_src[ADDR_W-1:0]};
            end
            ST_ROUTE_COMMIT: update = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/xbar_route_ctrl.sv
module xbar_route_ctrl
    import xbar_pkg::*;
#(
    parameter int GRID     = 2,
    parameter int TILE_DIM = 8
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      req_valid,
    output logic                                      req_ready,
    input  logic [$clog2(TILE_DIM)+$clog2(GRID)-1:0] req_out,
    input  logic [$clog2(TILE_DIM)+$clog2(GRID)-1:0] req_in,
    input  logic                                      req_en,
    output logic                                      tile_we,
    output logic [2*$clog2(GRID)-1:0]                 tile_sel,
    output logic [$clog2(TILE_DIM)-1:0]               tile_addr,
    output logic [$clog2(TILE_DIM):0]                 tile_data,
    output logic                                      tile_update
);

    localparam int ADDR_W = $clog2(TILE_DIM);
    localparam int ROW_W  = $clog2(GRID);
    localparam int PORT_W = ADDR_W + ROW_W;
    localparam int CNT_W  = $clog2(GRID * GRID * TILE_DIM);

    ctl_state_e        state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              fire;
    logic [PORT_W-1:0] rq_out;
    logic [PORT_W-1:0] rq_src;
    logic              rq_en;

    assign fire = req_valid && req_ready;

    xbar_ctl_fsm #(.GRID(GRID), .TILE_DIM(TILE_DIM), .CNT_W(CNT_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (fire),
        .state_q (state_q),
        .cnt_q   (cnt_q)
    );

    xbar_req_hold #(.PORT_W(PORT_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire     (fire),
        .in_out   (req_out),
        .in_src   (req_in),
        .in_en    (req_en),
        .hold_out (rq_out),
        .hold_src (rq_src),
        .hold_en  (rq_en)
    );

    xbar_cmd_gen #(.GRID(GRID), .TILE_DIM(TILE_DIM), .CNT_W(CNT_W)) u_cmd (
        .state_q (state_q),
        .cnt_q   (cnt_q),
        .rq_out  (rq_out),
        .rq_src  (rq_src),
        .rq_en   (rq_en),
        .ready   (req_ready),
        .we      (tile_we),
        .sel     (tile_sel),
        .addr    (tile_addr),
        .data    (tile_data),
        .update  (tile_update)
    );

endmodule

// File: rtl/xbar_route_chk.sv
module xbar_route_chk #(
    parameter int GRID     = 2,
    parameter int TILE_DIM = 8
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              req_valid,
    input logic                              req_ready,
    input logic                              tile_we,
    input logic [2*$clog2(GRID)-1:0]         tile_sel,
    input logic [$clog2(TILE_DIM)-1:0]       tile_addr,
    input logic [$clog2(TILE_DIM):0]         tile_data,
    input logic                              tile_update
);

    localparam int ADDR_W = $clog2(TILE_DIM);
    localparam int ROW_W  = $clog2(GRID);
    localparam int DATA_W = ADDR_W + 1;
    localparam int NTILE  = GRID * GRID;
    localparam int SWEEP  = NTILE * TILE_DIM;

    logic [DATA_W-1:0] hold_q [NTILE][TILE_DIM];
    logic [DATA_W-1:0] live_q [NTILE][TILE_DIM];
    logic [15:0]       sweep_wr_q;
    logic              seen_ready_q;
    logic              node_clash;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int t = 0; t < NTILE; t++)
                for (int a = 0; a < TILE_DIM; a++) begin
                    hold_q[t][a] <= '0;
                    live_q[t][a] <= '0;
                end
            sweep_wr_q   <= '0;
            seen_ready_q <= 1'b0;
        end else begin
            if (tile_we) begin
                hold_q[tile_sel][tile_addr] <= tile_data;
                if (!seen_ready_q) sweep_wr_q <= sweep_wr_q + 1'b1;
            end
            if (tile_update)
                for (int t = 0; t < NTILE; t++)
                    for (int a = 0; a < TILE_DIM; a++)
                        live_q[t][a] <= hold_q[t][a];
            if (req_ready) seen_ready_q <= 1'b1;
        end
    end

    always_comb begin
        node_clash = 1'b0;
        for (int c = 0; c < GRID; c++)
            for (int a = 0; a < TILE_DIM; a++) begin
                int on_cnt;
                on_cnt = 0;
                for (int r = 0; r < GRID; r++)
                    if (live_q[r*GRID+c][a][DATA_W-1]) on_cnt++;
                if (on_cnt > 1) node_clash = 1'b1;
            end
    end

    // R1
    sweep_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(req_ready) && !seen_ready_q) |-> (sweep_wr_q == 16'(SWEEP)));

    // R4
    partner_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tile_we && tile_data[DATA_W-1]) |->
            ($past(tile_we) && ($past(tile_addr) == tile_addr)
             && ($past(tile_sel[ROW_W-1:0]) == tile_sel[ROW_W-1:0])
             && ($past(tile_sel[2*ROW_W-1:ROW_W]) != tile_sel[2*ROW_W-1:ROW_W])
             && ($past(tile_data) == '0)));

    // R6
    update_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tile_update |-> !tile_we);

    // R6
    update_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tile_update |=> !tile_update);

    // R7
    busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R8
    wired_node_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !node_clash);

endmodule

bind xbar_route_ctrl xbar_route_chk #(.GRID(GRID), .TILE_DIM(TILE_DIM)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .tile_we     (tile_we),
    .tile_sel    (tile_sel),
    .tile_addr   (tile_addr),
    .tile_data   (tile_data),
    .tile_update (tile_update)
);

// File: tb/xbar_route_ctrl_tb.sv
`timescale 1ns/1ps
module xbar_route_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [3:0] req_out = '0;
    logic [3:0] req_in = '0;
    logic       req_en = 1'b0;
    logic       tile_we;
    logic [1:0] tile_sel;
    logic [2:0] tile_addr;
    logic [3:0] tile_data;
    logic       tile_update;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    // bench model of tile registers and observed command stream
    logic [3:0] hold_m [4][8];
    logic [3:0] live_m [4][8];
    logic [1:0] w_sel [8];
    logic [2:0] w_addr [8];
    logic [3:0] w_data [8];
    int         wr_n = 0;
    int         upd_n = 0;
    bit         order_bad = 0;
    bit         init_nonzero = 0;
    bit         cov [32];

    bit         exp_en [16];
    logic [3:0] exp_in [16];
    logic [3:0] cur_o, cur_i;
    bit         cur_e;

    xbar_route_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_out(req_out), .req_in(req_in), .req_en(req_en),
        .tile_we(tile_we), .tile_sel(tile_sel), .tile_addr(tile_addr),
        .tile_data(tile_data), .tile_update(tile_update)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [3:0] on_word(input logic [3:0] src);
        return {1'b1, src[2:0]};
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            if (tile_we) begin
                hold_m[tile_sel][tile_addr] = tile_data;
                if (wr_n < 8) begin
                    w_sel[wr_n] = tile_sel; w_addr[wr_n] = tile_addr; w_data[wr_n] = tile_data;
                end
                cov[{tile_sel, tile_addr}] = 1'b1;
                if (tile_data != 4'd0) init_nonzero = 1'b1;
                if (upd_n > 0) order_bad = 1'b1;
                wr_n++;
            end
            if (tile_update) begin
                if (tile_we) order_bad = 1'b1;
                upd_n++;
                for (int t = 0; t < 4; t++)
                    for (int a = 0; a < 8; a++) live_m[t][a] = hold_m[t][a];
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            chk(1'b0, "watchdog", cyc, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic scan_routes();
        for (int o = 0; o < 16; o++) begin
            int on_cnt;
            int got_in;
            on_cnt = 0; got_in = 0;
            for (int r = 0; r < 2; r++)
                if (live_m[r*2 + o/8][o%8][3]) begin
                    on_cnt++;
                    got_in = r*8 + live_m[r*2 + o/8][o%8][2:0];
                end
            chk(on_cnt <= 1, "R8 drivers on node", on_cnt, 1);
            chk((on_cnt == 1) == exp_en[o], "R9 enable state", on_cnt, int'(exp_en[o]));
            if (exp_en[o]) chk(got_in == exp_in[o], "R9 routed input", got_in, exp_in[o]);
        end
    endtask

    task automatic clear_mon();
        wr_n = 0; upd_n = 0; order_bad = 0;
    endtask

    // called at a negedge where req_valid and req_ready are both high
    task automatic finish_req();
        int low;
        logic [1:0] own_sel, mate_sel;
        logic [3:0] want;
        cur_o = req_out; cur_i = req_in; cur_e = req_en;
        clear_mon();
        @(negedge clk);
        req_valid = 1'b0;
        low = 0;
        while (!req_ready) begin low++; @(negedge clk); end
        chk(low == 3, "R7 ready low cycles", low, 3);
        chk(wr_n == 2, "R6 write count", wr_n, 2);
        chk(upd_n == 1, "R6 update count", upd_n, 1);
        chk(!order_bad, "R6 write after update", int'(order_bad), 0);
        own_sel  = {cur_i[3], cur_o[3]};
        mate_sel = {~cur_i[3], cur_o[3]};
        want = cur_e ? on_word(cur_i) : 4'd0;
        chk(w_sel[0] == mate_sel, cur_e ? "R4 partner tile" : "R5 first tile", w_sel[0], mate_sel);
        chk(w_data[0] == 4'd0, cur_e ? "R4 partner data" : "R5 first data", w_data[0], 0);
        chk(w_addr[0] == cur_o[2:0] && w_addr[1] == cur_o[2:0], "R2 address", w_addr[1], cur_o[2:0]);
        chk(w_sel[1] == own_sel, "R2 tile select", w_sel[1], own_sel);
        chk(w_data[1] == want, cur_e ? "R3 enable data" : "R5 second data", w_data[1], want);
        exp_en[cur_o] = cur_e;
        exp_in[cur_o] = cur_i;
        scan_routes();
    endtask

    task automatic send(input logic [3:0] o, input logic [3:0] i, input bit e, input bit now);
        if (!now) @(negedge clk);
        req_valid = 1'b1; req_out = o; req_in = i; req_en = e;
        while (!req_ready) @(negedge clk);
        finish_req();
    endtask

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd20240611);
        for (int k = 0; k < 16; k++) begin exp_en[k] = 0; exp_in[k] = '0; end
        for (int k = 0; k < 32; k++) cov[k] = 0;
        for (int t = 0; t < 4; t++)
            for (int a = 0; a < 8; a++) begin hold_m[t][a] = 4'hx; live_m[t][a] = 4'd0; end
        // request pending across reset and the start-up sweep
        req_valid = 1'b1; req_out = 4'd5; req_in = 4'd9; req_en = 1'b1;
        repeat (3) @(negedge clk);
        chk(!req_ready && !tile_update, "R1 reset outputs", int'(req_ready), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!req_ready, "R1 ready low in sweep", int'(req_ready), 0);
        while (!req_ready) @(negedge clk);
        chk(wr_n == 32, "R1 sweep writes", wr_n, 32);
        chk(upd_n == 1, "R1 sweep update", upd_n, 1);
        chk(!order_bad, "R1 update after writes", int'(order_bad), 0);
        chk(!init_nonzero, "R7 held request ignored in sweep", int'(init_nonzero), 0);
        begin
            int n_cov;
            n_cov = 0;
            for (int k = 0; k < 32; k++) if (cov[k]) n_cov++;
            chk(n_cov == 32, "R1 sweep coverage", n_cov, 32);
        end
        finish_req();
        // move output 5 to the other tile row, then back-to-back requests
        send(4'd5, 4'd2, 1'b1, 1'b0);
        send(4'd13, 4'd15, 1'b1, 1'b1);
        send(4'd13, 4'd0, 1'b1, 1'b1);
        send(4'd5, 4'd7, 1'b0, 1'b1);
        send(4'd5, 4'd7, 1'b0, 1'b0);
        // one input fanned to every output
        for (int o = 0; o < 16; o++) send(4'(o), 4'd11, 1'b1, o[0]);
        for (int n = 0; n < 200; n++)
            send(4'($urandom_range(15)), 4'($urandom_range(15)), ($urandom_range(3) != 0), $urandom_range(1) == 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule